// File: doc/BRIEF.md
# Output Buffer Status and Interrupt Arbiter

This block sits between the two receive channels of a keyboard/mouse host controller and the host-visible registers. Each channel raises a level signal while it has a byte waiting. The block folds those two levels and the controller's mode byte into one registered status byte, mirrors the buffer-full flags into the controller's output port image, picks which channel a data-port read is served from, and drives one interrupt line per channel.

Keyboard data always takes priority. When both channels have a byte waiting, the keyboard channel is reported, selected and interrupted on. The mouse flag and mouse interrupt appear only when auxiliary data is the only data pending. Interrupts are gated by the enable bits of the mode byte, and the keyboard interrupt is also held off while the keyboard interface is disabled. Every output is a register. A change on any input shows at the outputs after exactly one clock edge. Reading the status byte has no side effects, because the block has no read strobe at all.

The command decoder and the channel queues live outside. The decoder reports a completed self-test, reports each write to the command or data port, and supplies the output port image. The block keeps two sticky pieces of status: the self-test pass flag and the record of which port was written last.

Top module: `kbc_obf_irq_arbiter`

## Requirements
- R1: After reset, status_o is 0x18, outport_o is 0x03, and rd_sel_aux_o, irq_kbd_o and irq_mouse_o are 0.
- R2: status_o bit 0 (any buffer full) equals kbd_pending_i OR aux_pending_i from one clock earlier.
- R3: status_o bit 5 (auxiliary buffer full) is 1 exactly when, one clock earlier, aux_pending_i was 1 and kbd_pending_i was 0.
- R4: rd_sel_aux_o (1 = data read served by the auxiliary channel) follows the same condition as R3, so the keyboard wins when both channels are pending.
- R5: irq_mouse_o is 1 exactly when, one clock earlier, auxiliary data alone was pending and mode_i bit 1 (mouse interrupt enable) was 1.
- R6: irq_kbd_o is 1 exactly when, one clock earlier, kbd_pending_i was 1, mode_i bit 0 (keyboard interrupt enable) was 1 and mode_i bit 4 (keyboard interface disabled) was 0.
- R7: outport_o equals outport_i from one clock earlier, except that bit 4 is replaced by the R2 flag and bit 5 by the R3 flag.
- R8: status_o bit 2 becomes 1 one clock after selftest_done_i is 1 and stays 1 until reset.
- R9: status_o bit 3 becomes 1 one clock after cmd_wr_i is 1 and 0 one clock after data_wr_i alone is 1. If both are 1, cmd_wr_i wins. Otherwise the bit holds its value.
- R10: status_o bit 4 is always 1, and bits 1, 6 and 7 are always 0.
- R11: irq_kbd_o and irq_mouse_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kbd_pending_i | input | 1 | Keyboard channel has a byte waiting |
| aux_pending_i | input | 1 | Auxiliary channel has a byte waiting |
| mode_i | input | 8 | Controller mode byte |
| selftest_done_i | input | 1 | Self-test command completed |
| cmd_wr_i | input | 1 | Command port written this cycle |
| data_wr_i | input | 1 | Data port written this cycle |
| outport_i | input | 8 | Output port image from the command logic |
| status_o | output | 8 | Registered status byte |
| outport_o | output | 8 | Output port image with buffer-full flags merged in |
| rd_sel_aux_o | output | 1 | Data read is served by the auxiliary channel |
| irq_kbd_o | output | 1 | Keyboard interrupt level |
| irq_mouse_o | output | 1 | Mouse interrupt level |

## Verification
The bench builds the block with its default parameters. These select the variant in which a disabled keyboard interface also masks the keyboard interrupt, and they give the reset images 0x18 and 0x03. That lets random mode bytes reach the case where bit 4 suppresses an otherwise enabled keyboard interrupt. Directed steps cover both channels pending at once, and a simultaneous command and data write, so both priority orderings are exercised.

// File: rtl/kbc_stat_pkg.sv
package kbc_stat_pkg;

    localparam int BYTE_W = 8;

    // status byte bit positions (host software decodes these)
    localparam int ST_FULL     = 0;
    localparam int ST_SELFTEST = 2;
    localparam int ST_LASTCMD  = 3;
    localparam int ST_UNLOCK   = 4;
    localparam int ST_AUXFULL  = 5;

    // output port bit positions for the mirrored flags
    localparam int OP_FULL    = 4;
    localparam int OP_AUXFULL = 5;

    // mode byte bit positions
    localparam int MD_KBD_IRQ_EN = 0;
    localparam int MD_AUX_IRQ_EN = 1;
    localparam int MD_KBD_OFF    = 4;

    localparam logic [BYTE_W-1:0] PORT_FLAG_MASK =
        (BYTE_W'(1) << OP_FULL) | (BYTE_W'(1) << OP_AUXFULL);

    typedef struct packed {
        logic full;      // any channel pending
        logic aux_only;  // auxiliary alone pending
        logic kbd_sel;   // keyboard channel selected and pending
    } arb_t;

    typedef struct packed {
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] port;
        logic              sel_aux;
        logic              irq_kbd;
        logic              irq_aux;
    } regs_t;

endpackage

// File: rtl/kbc_src_arbiter.sv
module kbc_src_arbiter
    import kbc_stat_pkg::*;
(
    input  logic kbd_pending,
    input  logic aux_pending,
    output arb_t arb
);
    // keyboard has fixed priority over the auxiliary channel
    always_comb begin
        arb.full     = kbd_pending | aux_pending;
        arb.kbd_sel  = kbd_pending;
        arb.aux_only = aux_pending & ~kbd_pending;
    end
endmodule

// File: rtl/kbc_irq_gate.sv
module kbc_irq_gate
    import kbc_stat_pkg::*;
#(
    parameter bit GATE_ON_KBD_OFF = 1'b1
) (
    input  arb_t              arb,
    input  logic [BYTE_W-1:0] mode,
    output logic              irq_kbd,
    output logic              irq_aux
);
    logic kbd_en;
    logic aux_en;

    generate
        if (GATE_ON_KBD_OFF) begin : g_gate_off
            always_comb kbd_en = mode[MD_KBD_IRQ_EN] & ~mode[MD_KBD_OFF];
        end else begin : g_no_gate
            logic unused_off;
            always_comb unused_off = mode[MD_KBD_OFF];
            always_comb kbd_en = mode[MD_KBD_IRQ_EN];
        end
    endgenerate

    always_comb begin
        aux_en  = mode[MD_AUX_IRQ_EN];
        irq_kbd = arb.kbd_sel & kbd_en;
        irq_aux = arb.aux_only & aux_en;
    end
endmodule

// File: rtl/kbc_status_next.sv
module kbc_status_next
    import kbc_stat_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STATUS_RST = 8'h18
) (
    input  logic [BYTE_W-1:0] status_q,
    input  arb_t              arb,
    input  logic              selftest_done,
    input  logic              cmd_wr,
    input  logic              data_wr,
    output logic [BYTE_W-1:0] status_d
);
    logic last_cmd;

    always_comb begin
        // command write wins over a simultaneous data write
        if (cmd_wr)       last_cmd = 1'b1;
        else if (data_wr) last_cmd = 1'b0;
        else              last_cmd = status_q[ST_LASTCMD];

        status_d              = '0;
        status_d[ST_FULL]     = arb.full;
        status_d[ST_AUXFULL]  = arb.aux_only;
        status_d[ST_SELFTEST] = status_q[ST_SELFTEST] | selftest_done;
        status_d[ST_LASTCMD]  = last_cmd;
        status_d[ST_UNLOCK]   = STATUS_RST[ST_UNLOCK];
    end
endmodule

// File: rtl/kbc_obf_irq_arbiter.sv
module kbc_obf_irq_arbiter
    import kbc_stat_pkg::*;
#(
    parameter logic [BYTE_W-1:0] STATUS_RST      = 8'h18,
    parameter logic [BYTE_W-1:0] PORT_RST        = 8'h03,
    parameter bit                GATE_ON_KBD_OFF = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_pending_i,
    input  logic              aux_pending_i,
    input  logic [BYTE_W-1:0] mode_i,
    input  logic              selftest_done_i,
    input  logic              cmd_wr_i,
    input  logic              data_wr_i,
    input  logic [BYTE_W-1:0] outport_i,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] outport_o,
    output logic              rd_sel_aux_o,
    output logic              irq_kbd_o,
    output logic              irq_mouse_o
);
    localparam regs_t REGS_RST = '{
        status:  STATUS_RST,
        port:    PORT_RST,
        sel_aux: 1'b0,
        irq_kbd: 1'b0,
        irq_aux: 1'b0
    };

    regs_t             regs_d;
    regs_t             regs_q;
    arb_t              arb;
    logic              irq_kbd_c;
    logic              irq_aux_c;
    logic [BYTE_W-1:0] status_c;
    logic [BYTE_W-1:0] flags_c;

    kbc_src_arbiter i_arb (
        .kbd_pending (kbd_pending_i),
        .aux_pending (aux_pending_i),
        .arb         (arb)
    );

    kbc_irq_gate #(.GATE_ON_KBD_OFF(GATE_ON_KBD_OFF)) i_gate (
        .arb     (arb),
        .mode    (mode_i),
        .irq_kbd (irq_kbd_c),
        .irq_aux (irq_aux_c)
    );

    kbc_status_next #(.STATUS_RST(STATUS_RST)) i_stat (
        .status_q      (regs_q.status),
        .arb           (arb),
        .selftest_done (selftest_done_i),
        .cmd_wr        (cmd_wr_i),
        .data_wr       (data_wr_i),
        .status_d      (status_c)
    );

    always_comb begin
        flags_c             = '0;
        flags_c[OP_FULL]    = arb.full;
        flags_c[OP_AUXFULL] = arb.aux_only;

        regs_d         = regs_q;
        regs_d.status  = status_c;
        regs_d.port    = (outport_i & ~PORT_FLAG_MASK) | flags_c;
        regs_d.sel_aux = arb.aux_only;
        regs_d.irq_kbd = irq_kbd_c;
        regs_d.irq_aux = irq_aux_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign status_o     = regs_q.status;
    assign outport_o    = regs_q.port;
    assign rd_sel_aux_o = regs_q.sel_aux;
    assign irq_kbd_o    = regs_q.irq_kbd;
    assign irq_mouse_o  = regs_q.irq_aux;
endmodule

// File: rtl/kbc_obf_irq_chk.sv
module kbc_obf_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       kbd_pending_i,
    input logic       aux_pending_i,
    input logic [7:0] mode_i,
    input logic       selftest_done_i,
    input logic       cmd_wr_i,
    input logic       data_wr_i,
    input logic [7:0] outport_i,
    input logic [7:0] status_o,
    input logic [7:0] outport_o,
    input logic       rd_sel_aux_o,
    input logic       irq_kbd_o,
    input logic       irq_mouse_o
);
    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // R2
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> status_o[0] == ($past(kbd_pending_i) | $past(aux_pending_i)));
    // R3
    aux_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> status_o[5] == ($past(aux_pending_i) & ~$past(kbd_pending_i)));
    // R4
    kbd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(kbd_pending_i)) |-> !rd_sel_aux_o);
    // R5
    mouse_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mouse_o |-> status_o[5]);
    // R6
    kbd_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(mode_i[4])) |-> !irq_kbd_o);
    // R7
    port_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (outport_o[4] == status_o[0] && outport_o[5] == status_o[5]));
    // R8
    selftest_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_o[2]) |-> status_o[2]);
    // R10
    const_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[4] && !status_o[1] && !status_o[6] && !status_o[7]);
    // R11
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({irq_kbd_o, irq_mouse_o}) <= 1);

    logic unused_ok;
    always_comb unused_ok = ^{selftest_done_i, cmd_wr_i, data_wr_i, outport_i, mode_i};
endmodule

bind kbc_obf_irq_arbiter kbc_obf_irq_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .kbd_pending_i   (kbd_pending_i),
    .aux_pending_i   (aux_pending_i),
    .mode_i          (mode_i),
    .selftest_done_i (selftest_done_i),
    .cmd_wr_i        (cmd_wr_i),
    .data_wr_i       (data_wr_i),
    .outport_i       (outport_i),
    .status_o        (status_o),
    .outport_o       (outport_o),
    .rd_sel_aux_o    (rd_sel_aux_o),
    .irq_kbd_o       (irq_kbd_o),
    .irq_mouse_o     (irq_mouse_o)
);

// File: tb/test_kbc_obf_irq_arbiter.sv
`timescale 1ns/1ps
module test_kbc_obf_irq_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd_p = 1'b0, aux_p = 1'b0, st_done = 1'b0, cwr = 1'b0, dwr = 1'b0;
    logic [7:0] mode = 8'h00, oport = 8'h00;
    logic [7:0] status, port_o;
    logic       sel_aux, irq_k, irq_m;

    int n_run = 0;
    int n_fail = 0;
    logic exp_st = 1'b0;
    logic exp_cmd = 1'b1;

    always #4 clk = ~clk;  // 125 MHz

    kbc_obf_irq_arbiter i_kbc_obf_irq_arbiter (
        .clk(clk), .rst_n(rst_n),
        .kbd_pending_i(kbd_p), .aux_pending_i(aux_p), .mode_i(mode),
        .selftest_done_i(st_done), .cmd_wr_i(cwr), .data_wr_i(dwr),
        .outport_i(oport), .status_o(status), .outport_o(port_o),
        .rd_sel_aux_o(sel_aux), .irq_kbd_o(irq_k), .irq_mouse_o(irq_m)
    );

    function automatic logic [7:0] f_status(logic k, logic a, logic st, logic lc);
        f_status = {2'b00, a & ~k, 1'b1, lc, st, 1'b0, k | a};
    endfunction

    function automatic logic [7:0] f_port(logic [7:0] p, logic k, logic a);
        f_port = p;
        f_port[4] = k | a;
        f_port[5] = a & ~k;
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // drive on negedge, one posedge registers it, check at following negedge
    task automatic step(logic k, logic a, logic [7:0] m, logic st, logic c, logic d, logic [7:0] p);
        logic [7:0] es;
        kbd_p = k; aux_p = a; mode = m; st_done = st; cwr = c; dwr = d; oport = p;
        exp_st = exp_st | st;
        if (c) exp_cmd = 1'b1;
        else if (d) exp_cmd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        es = f_status(k, a, exp_st, exp_cmd);
        check8("R2/R3/R8/R9/R10 status", status, es);
        check8("R7 outport", port_o, f_port(p, k, a));
        check1("R4 read select", sel_aux, a & ~k);
        check1("R5 mouse irq", irq_m, a & ~k & m[1]);
        check1("R6 kbd irq", irq_k, k & m[0] & ~m[4]);
        check1("R11 irq exclusive", irq_k & irq_m, 1'b0);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        // R1 reset state
        check8("R1 status reset", status, 8'h18);
        check8("R1 outport reset", port_o, 8'h03);
        check1("R1 select reset", sel_aux, 1'b0);
        check1("R1 irq kbd reset", irq_k, 1'b0);
        check1("R1 irq mouse reset", irq_m, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        step(1'b1, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 8'h03); // R4 keyboard wins
        step(1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 8'hFF); // R3 aux only, R7 mask
        step(1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00); // R5 mouse irq disabled
        step(1'b1, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00); // R6 kbd disabled
        step(1'b1, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0, 8'h00); // R6 enabled, R9 cmd keeps 1
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00); // R9 data clears
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00); // R9 cmd wins
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00); // R8 self-test set
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00); // R8 sticky

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [7:0] rm;
            rm = 8'($urandom);
            step(1'($urandom), 1'($urandom), rm, ($urandom % 16) == 0,
                 ($urandom % 4) == 0, ($urandom % 4) == 0, 8'($urandom));
        end

        // R1 reset mid-run restores reset images and clears sticky bit
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check8("R1 status re-reset", status, 8'h18);
        check8("R1 outport re-reset", port_o, 8'h03);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule